// File: doc/BRIEF.md
# Line-Locked System Clock Divider with Phase Slip

This block turns a master clock running at six times the colour subcarrier into a system clock at three times the subcarrier. It does this by halving the master clock, and it carries the result as a phase bit and a clock-enable in the master domain. The subcarrier is not an integer multiple of the line rate. To keep the derived clock aligned to the picture lines, the divider is frozen for one master cycle when a horizontal sync edge arrives. Freezing the divider for one cycle moves the divided clock by half a period, which is 180 degrees. With the NTSC code this happens on every line. With the PAL codes it happens on every second line.

The block also produces a line-start strobe for the delay lines. The strobe comes from a line-length counter, and that counter is pulled back onto horizontal sync once per field, at the first horizontal edge after a vertical edge. This removes the slow drift that the PAL frame offset would otherwise build up. A run enable from the mode controller gates the whole block. While it is low, every output is quiet. When it returns, the divider phase and line parity start from a clean state, and the strobe waits for the next field resync.

Top module: `line_locked_divider`

## Requirements
- R1: While running and without a correction, `sys_phase` inverts on every master cycle, and `sys_ce` is high exactly in the running cycles where `sys_phase` is 1 and no correction is made.
- R2: In a correction cycle, `sys_phase` keeps its value into the following cycle and `sys_ce` is low, which delays the divided clock by one master cycle.
- R3: A rising edge of `hsync` or `vsync` first sampled at master edge k acts in the cycle between edges k+1 and k+2. That is the cycle in which a correction or strobe caused by it is visible.
- R4: With `std_sel` = 2'b10 (NTSC M), every horizontal edge causes a correction.
- R5: With `std_sel` = 2'b00, 2'b01 or 2'b11 (PAL M, PAL B/G/H/D/I, PAL N), a line parity bit toggles on each horizontal edge and is cleared by a vertical edge. A horizontal edge causes a correction only when parity is 1, so the first line after a vertical edge is not corrected and the second is.
- R6: `pal_mode` is 1 for `std_sel` 2'b00, 2'b01 and 2'b11, and 0 for 2'b10.
- R7: While `run_en` is 0, `sys_phase`, `sys_ce` and `line_start` are 0 in the same cycle. After a restart, the first running cycle has `sys_phase` = 0 and parity cleared, and `line_start` stays 0 until a field resync.
- R8: The first horizontal edge after a vertical edge raises `line_start` in its action cycle and restarts the line counter. From then on, `line_start` repeats every LINE_PAL master cycles (PAL codes) or every LINE_NTSC master cycles (NTSC code).
- R9: If a vertical edge and a horizontal edge act in the same cycle, parity is cleared, that horizontal edge does not resync the strobe, and the resync waits for the next horizontal edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, six times subcarrier |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync pulse, asynchronous |
| vsync | input | 1 | Vertical sync pulse, asynchronous |
| std_sel | input | 2 | Standard code (see R5, R6) |
| run_en | input | 1 | Run enable from mode controller |
| sys_phase | output | 1 | Divided system clock level |
| sys_ce | output | 1 | System clock enable, one per divided period |
| line_start | output | 1 | Delay-line start strobe |
| pal_mode | output | 1 | PAL family flag |

## Verification
On every cycle, the assertions check the divider's toggle and hold rules, the NTSC every-line slip, the PAL parity toggle, the clean state after a stop, and the counter restart at a field resync. Some behaviours are visible only over whole runs of lines and fields: the alternation of corrected PAL lines, the strobe period for each standard, the withholding of the strobe after a restart, and the handling of a vertical and horizontal edge arriving together. The bench's reference model covers these, cycle by cycle, across standard changes, stops and coincident sync edges.

// File: rtl/lld_pkg.sv
package lld_pkg;

  typedef enum logic [1:0] {
    STD_PAL_M  = 2'b00,
    STD_PAL_BG = 2'b01,
    STD_NTSC_M = 2'b10,
    STD_PAL_N  = 2'b11
  } std_code_e;

  // Every code except the NTSC one belongs to the PAL family
  function automatic logic std_is_pal(input logic [1:0] code);
    return code != STD_NTSC_M;
  endfunction

  // Strobe period in master cycles for the selected family
  function automatic int unsigned line_period(input logic pal,
                                              input int unsigned len_pal,
                                              input int unsigned len_ntsc);
    return pal ? len_pal : len_ntsc;
  endfunction

endpackage

// File: rtl/lld_edge_sync.sv
module lld_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  // Rising edge seen after the synchroniser stages
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/lld_phase_slip.sv
module lld_phase_slip (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pal,
  input  logic h_rise,
  input  logic v_rise,
  output logic phase_q,
  output logic parity_q,
  output logic stall
);

  // Slip on every line for NTSC, on odd-parity lines for PAL
  assign stall = run & h_rise & (~pal | parity_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      parity_q <= 1'b0;
    end else if (!run) begin
      phase_q  <= 1'b0;
      parity_q <= 1'b0;
    end else begin
      if (v_rise)      parity_q <= 1'b0;
      else if (h_rise) parity_q <= ~parity_q;
      if (!stall)      phase_q  <= ~phase_q;
    end
  end

  assert_divide_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !stall) |=> (phase_q != $past(phase_q)));

  assert_slip_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stall) |=> $stable(phase_q));

  assert_ntsc_every_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pal && h_rise) |=> $stable(phase_q));

  assert_pal_parity_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_rise && !v_rise) |=> (parity_q != $past(parity_q)));

endmodule

// File: rtl/lld_line_strobe.sv
module lld_line_strobe #(
  parameter int unsigned LINE_PAL  = 1702,
  parameter int unsigned LINE_NTSC = 1365
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pal,
  input  logic h_rise,
  input  logic v_rise,
  output logic strobe,
  output logic armed_q
);
  import lld_pkg::*;

  localparam int unsigned LMAX = (LINE_PAL > LINE_NTSC) ? LINE_PAL : LINE_NTSC;
  localparam int CW = $clog2(LMAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;
  logic          pending_q;
  logic          resync;
  logic          wrap;

  assign last_cnt = CW'(line_period(pal, LINE_PAL, LINE_NTSC) - 1);
  assign resync   = run & pending_q & h_rise;
  assign wrap     = run & armed_q & (cnt_q >= last_cnt);
  assign strobe   = resync | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      pending_q <= 1'b0;
    end else if (!run) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      pending_q <= v_rise | (pending_q & ~h_rise);
      if (resync) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assert_resync_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pending_q && h_rise) |=> (armed_q && cnt_q == '0));

  assert_strobe_withheld_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !pending_q) |-> !strobe);

endmodule

// File: rtl/line_locked_divider.sv
module line_locked_divider #(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned LINE_PAL    = 1702,
  parameter int unsigned LINE_NTSC   = 1365
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync,
  input  logic       vsync,
  input  logic [1:0] std_sel,
  input  logic       run_en,
  output logic       sys_phase,
  output logic       sys_ce,
  output logic       line_start,
  output logic       pal_mode
);
  import lld_pkg::*;

  localparam int NSYNC = 2;

  logic [NSYNC-1:0] sync_in;
  logic [NSYNC-1:0] sync_rise;
  logic             h_rise, v_rise;
  logic             phase_q, parity_q, stall;
  logic             strobe, armed_q;

  assign sync_in = {vsync, hsync};

  for (genvar i = 0; i < NSYNC; i++) begin : g_sync
    lld_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sync_in[i]),
      .rise (sync_rise[i])
    );
  end

  assign h_rise   = sync_rise[0];
  assign v_rise   = sync_rise[1];
  assign pal_mode = std_is_pal(std_sel);

  lld_phase_slip u_slip (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_en),
    .pal     (pal_mode),
    .h_rise  (h_rise),
    .v_rise  (v_rise),
    .phase_q (phase_q),
    .parity_q(parity_q),
    .stall   (stall)
  );

  lld_line_strobe #(.LINE_PAL(LINE_PAL), .LINE_NTSC(LINE_NTSC)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_en),
    .pal    (pal_mode),
    .h_rise (h_rise),
    .v_rise (v_rise),
    .strobe (strobe),
    .armed_q(armed_q)
  );

  assign sys_phase  = run_en & phase_q;
  assign sys_ce     = run_en & phase_q & ~stall;
  assign line_start = strobe;

  assert_restart_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_en) |-> (!phase_q && !parity_q && !armed_q));

endmodule

// File: tb/tb_line_locked_divider.sv
module tb_line_locked_divider;
  localparam int LP = 24;
  localparam int LN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, run_en = 1'b0;
  logic [1:0] std_sel = 2'b01;
  logic sys_phase, sys_ce, line_start, pal_mode;

  always #2.5 clk = ~clk;

  line_locked_divider #(.SYNC_STAGES(2), .LINE_PAL(LP), .LINE_NTSC(LN)) dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .std_sel(std_sel),
    .run_en(run_en), .sys_phase(sys_phase), .sys_ce(sys_ce),
    .line_start(line_start), .pal_mode(pal_mode)
  );

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  // Behavioural reference state
  bit hq[$];
  bit vq[$];
  bit m_phase, m_par, m_pend, m_armed;
  int m_cnt;
  int stall_count, strobe_count;

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  function automatic bit edge_of(input bit q[$]);
    return q[1] && !q[2];
  endfunction

  task automatic model_reset();
    hq = '{0, 0, 0};
    vq = '{0, 0, 0};
    m_phase = 0; m_par = 0; m_pend = 0; m_armed = 0; m_cnt = 0;
  endtask

  // One master cycle: inputs are already applied, compare, then advance
  task automatic cycle();
    bit he, ve, pal, stall, resync, wrap;
    int len;
    #1;
    he = edge_of(hq);
    ve = edge_of(vq);
    pal = (std_sel != 2'b10);
    len = pal ? LP : LN;
    stall = run_en && he && (!pal || m_par);
    resync = run_en && m_pend && he;
    wrap = run_en && m_armed && (m_cnt >= len - 1);
    if (stall) stall_count++;
    if (resync || wrap) strobe_count++;
    check({cur_req, " R1/R2 sys_phase"}, sys_phase, run_en && m_phase);
    check({cur_req, " R1/R2 sys_ce"}, sys_ce, run_en && m_phase && !stall);
    check({cur_req, " R8 line_start"}, line_start, resync || wrap);
    check("R6 pal_mode", pal_mode, pal);
    @(posedge clk);
    if (!run_en) begin
      m_phase = 0; m_par = 0; m_pend = 0; m_armed = 0; m_cnt = 0;
    end else begin
      if (ve) m_par = 0; else if (he) m_par = !m_par;
      if (!stall) m_phase = !m_phase;
      if (resync) begin m_cnt = 0; m_armed = 1; end
      else if (m_armed) m_cnt = wrap ? 0 : m_cnt + 1;
      m_pend = ve || (m_pend && !he);
    end
    hq.push_front(hsync); void'(hq.pop_back());
    vq.push_front(vsync); void'(vq.pop_back());
    @(negedge clk);
  endtask

  // Run n cycles with line period hp; a vertical pulse starts at vat
  task automatic run_lines(input int n, input int hp, input int hoff, input int vat);
    for (int c = 0; c < n; c++) begin
      hsync = ((c + hoff) % hp) < 3;
      vsync = (vat >= 0) && (c >= vat) && (c < vat + 5);
      cycle();
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // Reset state, R7
    check("R7 reset sys_phase", sys_phase, 1'b0);
    check("R7 reset line_start", line_start, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 code decode
    std_sel = 2'b00; #1 check("R6 code00", pal_mode, 1'b1);
    std_sel = 2'b01; #1 check("R6 code01", pal_mode, 1'b1);
    std_sel = 2'b10; #1 check("R6 code10", pal_mode, 1'b0);
    std_sel = 2'b11; #1 check("R6 code11", pal_mode, 1'b1);
    @(negedge clk);

    // R1 plain divide, no sync
    std_sel = 2'b01; run_en = 1'b1; cur_req = "R1";
    run_lines(12, 1000, 500, -1);

    // R3 latency: single h edge, PAL parity 0 -> no slip; second -> slip
    cur_req = "R3/R5";
    stall_count = 0;
    run_lines(48, LP, 0, -1);
    check("R5 one slip per two lines", 1'(stall_count == 1), 1'b1);

    // R5/R8 PAL fields with resync
    cur_req = "R5/R8";
    strobe_count = 0;
    run_lines(400, LP, 5, 60);
    check("R8 strobes present after field", 1'(strobe_count >= 10), 1'b1);

    // R4 NTSC every line
    std_sel = 2'b10; cur_req = "R4";
    stall_count = 0;
    run_lines(200, LN, 0, 30);
    check("R4 slip per line", 1'(stall_count == 10), 1'b1);

    // R9 vertical and horizontal edges together
    std_sel = 2'b11; cur_req = "R9";
    run_lines(150, LP, 0, 48);

    // R7 stop and restart
    cur_req = "R7";
    run_en = 1'b0;
    run_lines(10, LP, 0, -1);
    run_en = 1'b1;
    strobe_count = 0;
    run_lines(70, LP, 3, -1);
    check("R7 strobe withheld after restart", 1'(strobe_count == 0), 1'b1);
    run_lines(120, LP, 3, 20);

    // PAL M with changing line offset
    std_sel = 2'b00; cur_req = "R5";
    run_lines(200, LP, 11, 90);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule